// File: doc/BRIEF.md
# I2C Controller Interrupt Status Collector

This block sits beside an I2C controller and gathers its event pulses (underflow, overflow, read request, transmit abort, receive done, bus activity, start, stop and general call) into sticky status bits. It also derives two level conditions from the FIFO fill levels and two programmable thresholds. A full-width mask register selects which status bits reach a single registered interrupt line. The line is asserted only while the enable bit of the control register is set. Software reads the raw and masked status vectors through a simple read/write register port.

Each sticky bit has its own read-to-clear address. Servicing one source therefore never discards another event that lands during the service. A combined clear address wipes every sticky bit at once. When a transmit abort is signalled, an abort-cause word is captured. It is held by a two-state machine, `CAUSE_EMPTY` and `CAUSE_HELD`. The machine takes the `capture` transition (either state to `CAUSE_HELD`) on an abort pulse. It takes the `release` transition (`CAUSE_HELD` to `CAUSE_EMPTY`) when the abort's own clear address is read without a new abort in that cycle. If neither happens, it stays where it is.

Register map (5-bit address): 0 control (bit 0 = enable, all bits read back), 1 mask (all bits read back), 2 raw status, 3 masked status, 4 TX threshold, 5 RX threshold, 6 abort cause, 7 combined clear, 8+i clear of sticky source i (8 to 17). Status bit positions: 0 RX underflow, 1 RX overflow, 2 TX overflow, 3 read request, 4 TX abort, 5 RX done, 6 activity, 7 stop seen, 8 start seen, 9 general call, 10 TX below threshold, 11 RX above threshold. Event input bit i drives sticky bit i.

Top module: `i2c_irq_collector`

## Requirements
- R1: After reset the control, mask, threshold and abort-cause registers and all ten sticky bits read 0, and `irq` and `reg_rdata` are 0.
- R2: A 1 on `ev_pulse[i]` (i in 0..9) at a clock edge sets raw status bit i (address 2), and the bit stays set until it is cleared.
- R3: The masked status (address 3) equals the raw status bitwise ANDed with bits 11:0 of the mask register (address 1).
- R4: Reading address 8+i returns the prior value of sticky bit i in bit 0 (other bits 0) and clears only bit i. Every other sticky bit is left as it was.
- R5: Reading address 7 returns the ten sticky bits in bits 9:0 and clears all of them.
- R6: When `ev_pulse[i]` is 1 in the same cycle as a read of that bit's clear address (8+i) or of address 7, the bit remains set afterwards.
- R7: Status bit 10 is 1 exactly while `tx_level` is less than or equal to the TX threshold (address 4). Status bit 11 is 1 exactly while `rx_level` is greater than the RX threshold (address 5), so an RX threshold of 0 fires on one entry.
- R8: `irq` is the OR of the masked status bits, registered one clock later, and gated by control bit 0. While control bit 0 is 0, `irq` is 0 on the following cycle.
- R9: An abort pulse (`ev_pulse[4]`) loads `abort_cause` into the cause register (address 6), even if a cause is already held. The value stays until address 12 is read, which resets it to 0. Reading address 7 or any other address leaves it unchanged, and an abort pulse in the same cycle as the address-12 read wins.
- R10: Read data appears on `reg_rdata` one cycle after `reg_rd`, is 0 in cycles that follow no read and for unmapped addresses, and writes take effect only at addresses 0, 1, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 10 | One-cycle event pulses, bit i sets sticky bit i |
| abort_cause | input | CAUSE_W | Abort reason, sampled with `ev_pulse[4]` |
| tx_level | input | LVL_W | TX FIFO fill level |
| rx_level | input | LVL_W | RX FIFO fill level |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data |
| irq | output | 1 | Registered interrupt line |

## Verification
The critical collision is an event pulse arriving in the very cycle that software reads that event's clear address, or the combined clear, or the abort-cause clear. The bench provokes this directly for a read-request pulse against its own clear and an abort pulse against the cause clear. It then lets random traffic, with pulses on every source and reads spread over all addresses, land such pairs repeatedly. Each outcome is judged by reading the raw status and the cause register afterwards against a reference model that applies the "set wins over clear" rule.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int NUM_STICKY = 10;
    localparam int NUM_STATUS = NUM_STICKY + 2;
    localparam int ADDR_W     = 5;

    localparam int BIT_ABORT    = 4;
    localparam int BIT_TX_LOW   = NUM_STICKY;
    localparam int BIT_RX_HIGH  = NUM_STICKY + 1;

    localparam int A_CTRL      = 0;
    localparam int A_MASK      = 1;
    localparam int A_RAW       = 2;
    localparam int A_MASKED    = 3;
    localparam int A_TX_THR    = 4;
    localparam int A_RX_THR    = 5;
    localparam int A_CAUSE     = 6;
    localparam int A_CLR_ALL   = 7;
    localparam int A_CLR_BASE  = 8;
    localparam int A_LAST      = A_CLR_BASE + NUM_STICKY - 1;

    typedef enum logic {
        CAUSE_EMPTY = 1'b0,
        CAUSE_HELD  = 1'b1
    } cause_state_t;

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr_one,
    input  logic         clr_all,
    output logic [N-1:0] sticky
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic wipe;
        assign wipe = clr_one[g] | clr_all;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sticky[g] <= 1'b0;
            end else if (ev[g]) begin
                sticky[g] <= 1'b1;
            end else if (wipe) begin
                sticky[g] <= 1'b0;
            end
        end

        // R2
        set_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev[g] |=> sticky[g]);

        // R4
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wipe && !ev[g]) |=> !sticky[g]);

        // R4
        hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky[g] && !wipe) |=> sticky[g]);
    end

endmodule

// File: rtl/irq_level_detect.sv
module irq_level_detect #(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    output logic             tx_low,
    output logic             rx_high
);

    always_comb begin
        tx_low  = (tx_level <= tx_thr);
        rx_high = (rx_level >  rx_thr);
    end

endmodule

// File: rtl/irq_abort_capture.sv
module irq_abort_capture
    import i2c_irq_pkg::*;
#(
    parameter int CAUSE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort_ev,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic               release_rd,
    output logic [CAUSE_W-1:0] cause_q
);

    cause_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAUSE_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAUSE_EMPTY: if (abort_ev) state_d = CAUSE_HELD;
            CAUSE_HELD: begin
                if (abort_ev)        state_d = CAUSE_HELD;
                else if (release_rd) state_d = CAUSE_EMPTY;
            end
            default: state_d = CAUSE_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (abort_ev) begin
            cause_q <= cause_in;
        end else if (release_rd) begin
            cause_q <= '0;
        end
    end

    // R9
    cause_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAUSE_HELD && !abort_ev && !release_rd) |=> $stable(cause_q));

    // R9
    cause_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_rd && !abort_ev) |=> (cause_q == '0 && state_q == CAUSE_EMPTY));

    // R9
    cause_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAUSE_EMPTY) |-> (cause_q == '0));

endmodule

// File: rtl/i2c_irq_collector.sv
module i2c_irq_collector
    import i2c_irq_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int LVL_W   = 4,
    parameter int CAUSE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STICKY-1:0] ev_pulse,
    input  logic [CAUSE_W-1:0]    abort_cause,
    input  logic [LVL_W-1:0]      tx_level,
    input  logic [LVL_W-1:0]      rx_level,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  irq
);

    localparam logic [ADDR_W-1:0] AD_CTRL    = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_MASK    = ADDR_W'(A_MASK);
    localparam logic [ADDR_W-1:0] AD_RAW     = ADDR_W'(A_RAW);
    localparam logic [ADDR_W-1:0] AD_MASKED  = ADDR_W'(A_MASKED);
    localparam logic [ADDR_W-1:0] AD_TX_THR  = ADDR_W'(A_TX_THR);
    localparam logic [ADDR_W-1:0] AD_RX_THR  = ADDR_W'(A_RX_THR);
    localparam logic [ADDR_W-1:0] AD_CAUSE   = ADDR_W'(A_CAUSE);
    localparam logic [ADDR_W-1:0] AD_CLR_ALL = ADDR_W'(A_CLR_ALL);

    logic [REG_W-1:0]      ctrl_q, mask_q;
    logic [LVL_W-1:0]      tx_thr_q, rx_thr_q;
    logic [NUM_STICKY-1:0] sticky, clr_hit, clr_one;
    logic                  clr_all;
    logic                  tx_low, rx_high;
    logic [NUM_STATUS-1:0] raw_status, masked_status;
    logic [CAUSE_W-1:0]    cause_q;
    logic [REG_W-1:0]      rd_val;

    // Clear-address decode, one strobe per sticky source
    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_clr
        assign clr_hit[g] = (reg_addr == ADDR_W'(A_CLR_BASE + g));
        assign clr_one[g] = reg_rd & clr_hit[g];
    end
    assign clr_all = reg_rd & (reg_addr == AD_CLR_ALL);

    irq_sticky_bank #(.N(NUM_STICKY)) i_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev_pulse),
        .clr_one (clr_one),
        .clr_all (clr_all),
        .sticky  (sticky)
    );

    irq_level_detect #(.LVL_W(LVL_W)) i_level (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (tx_thr_q),
        .rx_thr   (rx_thr_q),
        .tx_low   (tx_low),
        .rx_high  (rx_high)
    );

    irq_abort_capture #(.CAUSE_W(CAUSE_W)) i_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_ev   (ev_pulse[BIT_ABORT]),
        .cause_in   (abort_cause),
        .release_rd (clr_one[BIT_ABORT]),
        .cause_q    (cause_q)
    );

    always_comb begin
        raw_status                 = '0;
        raw_status[NUM_STICKY-1:0] = sticky;
        raw_status[BIT_TX_LOW]     = tx_low;
        raw_status[BIT_RX_HIGH]    = rx_high;
        masked_status              = raw_status & mask_q[NUM_STATUS-1:0];
    end

    // Software-writable configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            mask_q   <= '0;
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == AD_CTRL)   ctrl_q   <= reg_wdata;
            if (reg_addr == AD_MASK)   mask_q   <= reg_wdata;
            if (reg_addr == AD_TX_THR) tx_thr_q <= reg_wdata[LVL_W-1:0];
            if (reg_addr == AD_RX_THR) rx_thr_q <= reg_wdata[LVL_W-1:0];
        end
    end

    // Read mux
    always_comb begin
        rd_val = '0;
        case (reg_addr)
            AD_CTRL:    rd_val = ctrl_q;
            AD_MASK:    rd_val = mask_q;
            AD_RAW:     rd_val = REG_W'(raw_status);
            AD_MASKED:  rd_val = REG_W'(masked_status);
            AD_TX_THR:  rd_val = REG_W'(tx_thr_q);
            AD_RX_THR:  rd_val = REG_W'(rx_thr_q);
            AD_CAUSE:   rd_val = REG_W'(cause_q);
            AD_CLR_ALL: rd_val = REG_W'(sticky);
            default: begin
                for (int i = 0; i < NUM_STICKY; i++) begin
                    if (clr_hit[i]) rd_val = REG_W'(sticky[i]);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            irq       <= 1'b0;
        end else begin
            reg_rdata <= reg_rd ? rd_val : '0;
            irq       <= ctrl_q[0] & (|masked_status);
        end
    end

    // R8
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |=> !irq);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr > ADDR_W'(A_LAST)) |=> (reg_rdata == '0));

    // R10
    no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));

endmodule

// File: tb/test_i2c_irq_collector.sv
module test_i2c_irq_collector;
    import i2c_irq_pkg::*;

    localparam int REG_W = 16;
    localparam int LVL_W = 4;
    localparam int CW    = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                  rst_n;
    logic [NUM_STICKY-1:0] ev_pulse;
    logic [CW-1:0]         abort_cause;
    logic [LVL_W-1:0]      tx_level, rx_level;
    logic                  reg_rd, reg_wr;
    logic [ADDR_W-1:0]     reg_addr;
    logic [REG_W-1:0]      reg_wdata, reg_rdata;
    logic                  irq;

    i2c_irq_collector #(.REG_W(REG_W), .LVL_W(LVL_W), .CAUSE_W(CW)) i_i2c_irq_collector (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .abort_cause(abort_cause),
        .tx_level(tx_level), .rx_level(rx_level), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Reference model state
    logic [NUM_STICKY-1:0] m_lat;
    logic [REG_W-1:0]      m_ctrl, m_mask;
    logic [LVL_W-1:0]      m_txthr, m_rxthr;
    logic [CW-1:0]         m_cause;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    function automatic logic [NUM_STATUS-1:0] model_raw(input logic [LVL_W-1:0] txl,
                                                        input logic [LVL_W-1:0] rxl);
        return {rxl > m_rxthr, txl <= m_txthr, m_lat};
    endfunction

    function automatic logic [REG_W-1:0] model_read(input int a, input logic [NUM_STATUS-1:0] raw);
        if (a == 0)  return m_ctrl;
        if (a == 1)  return m_mask;
        if (a == 2)  return REG_W'(raw);
        if (a == 3)  return REG_W'(raw & m_mask[NUM_STATUS-1:0]);
        if (a == 4)  return REG_W'(m_txthr);
        if (a == 5)  return REG_W'(m_rxthr);
        if (a == 6)  return REG_W'(m_cause);
        if (a == 7)  return REG_W'(m_lat);
        if (a >= 8 && a < 8 + NUM_STICKY) return REG_W'(m_lat[a-8]);
        return '0;
    endfunction

    function automatic string tag_of(input int a, input bit rd);
        if (!rd)     return "R10";
        if (a == 2)  return "R2";
        if (a == 3)  return "R3";
        if (a == 6)  return "R9";
        if (a == 7)  return "R5";
        if (a >= 8 && a < 8 + NUM_STICKY) return "R4";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic [NUM_STICKY-1:0] ev, input logic [CW-1:0] cause,
                         input logic [LVL_W-1:0] txl, input logic [LVL_W-1:0] rxl,
                         input bit rd, input bit wr, input int a,
                         input logic [REG_W-1:0] wd, input string tag);
        logic [NUM_STATUS-1:0] raw;
        logic                  e_irq;
        logic [REG_W-1:0]      e_rd;
        ev_pulse    = ev;
        abort_cause = cause;
        tx_level    = txl;
        rx_level    = rxl;
        reg_rd      = rd;
        reg_wr      = wr;
        reg_addr    = ADDR_W'(a);
        reg_wdata   = wd;
        raw   = model_raw(txl, rxl);
        e_irq = m_ctrl[0] & (|(raw & m_mask[NUM_STATUS-1:0]));
        e_rd  = rd ? model_read(a, raw) : '0;
        @(posedge clk);
        for (int i = 0; i < NUM_STICKY; i++) begin
            if (ev[i]) m_lat[i] = 1'b1;
            else if (rd && (a == 7 || a == 8 + i)) m_lat[i] = 1'b0;
        end
        if (ev[BIT_ABORT]) m_cause = cause;
        else if (rd && a == 8 + BIT_ABORT) m_cause = '0;
        if (wr) begin
            if (a == 0) m_ctrl  = wd;
            if (a == 1) m_mask  = wd;
            if (a == 4) m_txthr = wd[LVL_W-1:0];
            if (a == 5) m_rxthr = wd[LVL_W-1:0];
        end
        @(negedge clk);
        check((tag != "") ? tag : tag_of(a, rd), reg_rdata, e_rd);
        check("R8", REG_W'(irq), REG_W'(e_irq));
    endtask

    task automatic rd_at(input int a, input string tag);
        cycle('0, '0, tx_level, rx_level, 1'b1, 1'b0, a, '0, tag);
    endtask

    task automatic wr_at(input int a, input logic [REG_W-1:0] d);
        cycle('0, '0, tx_level, rx_level, 1'b0, 1'b1, a, d, "R10");
    endtask

    task automatic pulse(input logic [NUM_STICKY-1:0] ev, input logic [CW-1:0] c);
        cycle(ev, c, tx_level, rx_level, 1'b0, 1'b0, 0, '0, "");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0;
        ev_pulse = '0; abort_cause = '0; tx_level = '0; rx_level = '0;
        reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        m_lat = '0; m_ctrl = '0; m_mask = '0; m_txthr = '0; m_rxthr = '0; m_cause = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state through every mapped address
        check("R1", REG_W'(irq), '0);
        check("R1", reg_rdata, '0);
        for (int a = 0; a < 8 + NUM_STICKY; a++) rd_at(a, "R1");

        // Enable, unmask everything
        wr_at(0, 16'h0001);
        wr_at(1, 16'hFFFF);
        tx_level = 4'd5;

        // R2 / R4: set two sources, clear only one
        pulse(10'b00_0000_0011, '0);
        rd_at(2, "R2");
        rd_at(8, "R4");
        rd_at(2, "R4");
        rd_at(9, "R4");

        // R6: event in same cycle as its own clear
        cycle(10'b00_0000_1000, '0, tx_level, rx_level, 1'b1, 1'b0, 11, '0, "R6");
        rd_at(2, "R6");
        cycle(10'b00_0000_1000, '0, tx_level, rx_level, 1'b1, 1'b0, 7, '0, "R6");
        rd_at(2, "R6");

        // R3: partial mask
        wr_at(1, 16'h0108);
        pulse(10'b01_0000_0000, '0);
        rd_at(3, "R3");

        // R7: thresholds, RX threshold 0 means one entry
        wr_at(5, 16'h0000);
        cycle('0, '0, 4'd5, 4'd1, 1'b1, 1'b0, 2, '0, "R7");
        cycle('0, '0, 4'd5, 4'd0, 1'b1, 1'b0, 2, '0, "R7");
        wr_at(4, 16'h0003);
        cycle('0, '0, 4'd3, 4'd0, 1'b1, 1'b0, 2, '0, "R7");
        cycle('0, '0, 4'd4, 4'd0, 1'b1, 1'b0, 2, '0, "R7");

        // R9: abort cause hold and release
        pulse(10'b00_0001_0000, 16'hBEEF);
        rd_at(7, "R5");
        rd_at(6, "R9");
        rd_at(10, "R9");
        rd_at(6, "R9");
        pulse(10'b00_0001_0000, 16'h1234);
        rd_at(6, "R9");
        cycle(10'b00_0001_0000, 16'h5A5A, tx_level, rx_level, 1'b1, 1'b0, 12, '0, "R9");
        rd_at(6, "R9");
        rd_at(12, "R9");
        rd_at(6, "R9");

        // R5: combined clear of many sources
        pulse(10'b11_1010_0101, '0);
        rd_at(7, "R5");
        rd_at(2, "R5");

        // R8: gating by enable
        wr_at(1, 16'hFFFF);
        pulse(10'b00_0100_0000, '0);
        wr_at(0, 16'h0000);
        rd_at(2, "R8");
        wr_at(0, 16'h8001);
        rd_at(0, "R10");
        wr_at(20, 16'hFFFF);
        rd_at(20, "R10");

        // Constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [NUM_STICKY-1:0] ev;
            int  a;
            bit  rd, wr;
            logic [REG_W-1:0] wd;
            for (int i = 0; i < NUM_STICKY; i++) ev[i] = ($urandom_range(0, 9) == 0);
            a  = $urandom_range(0, 19);
            rd = ($urandom_range(0, 2) != 0);
            wr = ($urandom_range(0, 9) == 0);
            wd = REG_W'($urandom);
            if (wr && a == 0 && $urandom_range(0, 3) != 0) wd[0] = 1'b1;
            cycle(ev, CW'($urandom), LVL_W'($urandom_range(0, 8)), LVL_W'($urandom_range(0, 8)),
                  rd, wr, a, wd, "");
        end

        finish_run();
    end

endmodule